// File: doc/BRIEF.md
# Exception Entry Sequencer

This block moves a processor core into an exception or interrupt handler. Each cycle in which it is idle, it looks at three possible causes. The first is a software break, which carries a trap number. The second is an MMU fault, which carries a fault vector and the address of the faulting instruction. The third is an external interrupt, whose vector comes from the interrupt controller. It picks one cause and records the vector number, the return address and the current status word. It then reads the handler address from a vector table through a single memory read port. The table holds one word per vector, starting at the exception base address.

When the read returns, the sequencer spends one cycle committing the new context. It presents the handler address as the new program counter, the return address for the exception-return register, and a pushed status word. Pushing keeps the two top status bits and moves the low 20 bits up by ten places, which leaves the ten lowest bits clear. The core writes all three values in that single commit cycle. A busy output tells the core that an entry is under way.

An external interrupt is only accepted when the interrupt-enable flag is set in the status word and its vector is high enough to belong to the interrupt range. If either condition fails, the request stays pending at the input until it can be taken.

Top module: `exc_entry_seq`

## Requirements
- R1: On acceptance the sequencer raises `rd_req_o` in the next cycle with `rd_addr_o` = `ebp_i` + vector × 4 (modulo 2^XLEN), captured at acceptance. It holds request and address unchanged until a cycle with `rd_valid_i` high. In the cycle after that, `commit_o` is high and `new_pc_o` equals the `rd_data_i` word of that cycle.
- R2: A software break gives vector `brk_vec_i`, return address `cur_pc_i` + 2 (modulo 2^XLEN) and `cause_o` = 1.
- R3: An MMU fault gives vector `mmu_vec_i`, return address `mmu_pc_i` and `cause_o` = 2.
- R4: A taken external interrupt gives vector `irq_vec_i`, return address `cur_pc_i` and `cause_o` = 3.
- R5: An external interrupt whose `irq_vec_i` is below 0x30 is never accepted, and `accept_o` and `busy_o` stay low.
- R6: An external interrupt is accepted only while bit 8 of `ccs_i` (interrupt enable) is 1. A request held while the bit is 0 is accepted once the bit becomes 1.
- R7: At commit, `new_ccs_o` = (S AND 0xC0000000) OR ((S << 12) >> 2) on 32 bits, where S is `ccs_i` at acceptance.
- R8: When causes arrive in the same cycle, an MMU fault wins over a break, and a break wins over an external interrupt.
- R9: `accept_o` is high only in an idle cycle in which a cause is taken. `busy_o` is high from the next cycle through the single-cycle `commit_o` pulse, then drops. Requests seen while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_pc_i | input | XLEN | Program counter of the current instruction |
| ccs_i | input | XLEN | Current status word; bit 8 is interrupt enable |
| ebp_i | input | XLEN | Exception base address of the vector table |
| brk_req_i | input | 1 | Software break request |
| brk_vec_i | input | VEC_W | Trap number of the break |
| mmu_req_i | input | 1 | MMU fault request |
| mmu_vec_i | input | VEC_W | Fault vector from the MMU |
| mmu_pc_i | input | XLEN | Address of the faulting instruction |
| irq_req_i | input | 1 | Interrupt request line from the interrupt controller |
| irq_vec_i | input | VEC_W | Interrupt vector bus |
| accept_o | output | 1 | A cause is taken in this cycle |
| busy_o | output | 1 | Entry sequence in progress |
| rd_req_o | output | 1 | Vector table read request |
| rd_addr_o | output | XLEN | Vector table read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | XLEN | Read data (handler address) |
| commit_o | output | 1 | Single-cycle strobe: write PC, return register and status |
| cause_o | output | 2 | Cause at commit: 1 break, 2 MMU fault, 3 interrupt |
| vec_o | output | VEC_W | Vector number at commit |
| new_pc_o | output | XLEN | Handler address for the program counter |
| new_erp_o | output | XLEN | Value for the exception-return register |
| new_ccs_o | output | XLEN | Pushed status word |

## Verification
The bench goes after the interrupt gate at vector 0x2F against 0x30 and with the enable bit cleared. A design with a wrong compare or a missing gate would start an entry, and the bench would see an unexpected `accept_o` and a read request. It drives all three causes in one cycle to catch a wrong priority, which would show up as the wrong vector and return address at commit. It also uses a base near the top of the address space and a program counter of all ones, to catch address or return-offset arithmetic that fails to wrap. Read latencies from zero to three cycles, and a new cause asserted while busy, show whether the design commits early, commits twice or loses the returned handler word.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_COMMIT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_BREAK = 2'd1,
        CAUSE_MMU   = 2'd2,
        CAUSE_IRQ   = 2'd3
    } exc_cause_e;

endpackage

// File: rtl/exc_cause_arb.sv
// Picks one entry cause per cycle: MMU fault, then break, then a gated interrupt.
module exc_cause_arb
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int VEC_W    = 8,
    parameter int IRQ_MIN  = 'h30,
    parameter int BRK_STEP = 2
) (
    input  logic             brk_req,
    input  logic [VEC_W-1:0] brk_vec,
    input  logic             mmu_req,
    input  logic [VEC_W-1:0] mmu_vec,
    input  logic [XLEN-1:0]  mmu_pc,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             irq_en,
    input  logic [XLEN-1:0]  cur_pc,
    output logic             take,
    output exc_cause_e       cause,
    output logic [VEC_W-1:0] vec,
    output logic [XLEN-1:0]  ret_pc
);

    localparam logic [VEC_W-1:0] IrqFloor = VEC_W'(IRQ_MIN);
    localparam logic [XLEN-1:0]  BrkOfs   = XLEN'(BRK_STEP);

    logic irq_ok;

    // R5/R6: vector must lie in the interrupt range and the core must accept interrupts
    assign irq_ok = irq_req && (irq_vec >= IrqFloor) && irq_en;

    always_comb begin
        take   = 1'b0;
        cause  = CAUSE_NONE;
        vec    = '0;
        ret_pc = cur_pc;
        if (mmu_req) begin
            // R3, R8: faulting instruction is restarted on return
            take   = 1'b1;
            cause  = CAUSE_MMU;
            vec    = mmu_vec;
            ret_pc = mmu_pc;
        end else if (brk_req) begin
            // R2: return past the break instruction
            take   = 1'b1;
            cause  = CAUSE_BREAK;
            vec    = brk_vec;
            ret_pc = cur_pc + BrkOfs;
        end else if (irq_ok) begin
            // R4: interrupt taken between instructions
            take   = 1'b1;
            cause  = CAUSE_IRQ;
            vec    = irq_vec;
            ret_pc = cur_pc;
        end
    end

endmodule

// File: rtl/exc_ccs_push.sv
// Status push: top KEEP_W bits stay, the next field moves up by PUSH_W bits.
module exc_ccs_push #(
    parameter int XLEN   = 32,
    parameter int KEEP_W = 2,
    parameter int PUSH_W = 10
) (
    input  logic [XLEN-1:0] ccs_in,
    output logic [XLEN-1:0] ccs_out
);

    localparam logic [XLEN-1:0] KeepMask = ~({XLEN{1'b1}} >> KEEP_W);

    generate
        if (PUSH_W == 0) begin : g_flat
            assign ccs_out = ccs_in;
        end else begin : g_push
            logic [XLEN-1:0] lifted;
            // drop the bits that fall into the kept field, land the rest PUSH_W higher
            assign lifted  = (ccs_in << (KEEP_W + PUSH_W)) >> KEEP_W;
            assign ccs_out = (ccs_in & KeepMask) | lifted;
        end
    endgenerate

endmodule

// File: rtl/exc_vec_addr.sv
// Vector table slot address: base plus vector scaled to a word.
module exc_vec_addr #(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8
) (
    input  logic [XLEN-1:0]  base,
    input  logic [VEC_W-1:0] vec,
    output logic [XLEN-1:0]  addr
);

    localparam int PadW = XLEN - VEC_W - 2;

    logic [XLEN-1:0] offset;

    assign offset = {{PadW{1'b0}}, vec, 2'b00};
    assign addr   = base + offset;

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry sequencer: cause select, table fetch, single-cycle commit.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int VEC_W    = 8,
    parameter int IRQ_MIN  = 'h30,
    parameter int IE_BIT   = 8,
    parameter int BRK_STEP = 2,
    parameter int KEEP_W   = 2,
    parameter int PUSH_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  cur_pc_i,
    input  logic [XLEN-1:0]  ccs_i,
    input  logic [XLEN-1:0]  ebp_i,
    input  logic             brk_req_i,
    input  logic [VEC_W-1:0] brk_vec_i,
    input  logic             mmu_req_i,
    input  logic [VEC_W-1:0] mmu_vec_i,
    input  logic [XLEN-1:0]  mmu_pc_i,
    input  logic             irq_req_i,
    input  logic [VEC_W-1:0] irq_vec_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             rd_req_o,
    output logic [XLEN-1:0]  rd_addr_o,
    input  logic             rd_valid_i,
    input  logic [XLEN-1:0]  rd_data_i,
    output logic             commit_o,
    output logic [1:0]       cause_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [XLEN-1:0]  new_pc_o,
    output logic [XLEN-1:0]  new_erp_o,
    output logic [XLEN-1:0]  new_ccs_o
);

    typedef struct packed {
        seq_state_e       st;
        exc_cause_e       cause;
        logic [VEC_W-1:0] vec;
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  erp;
        logic [XLEN-1:0]  ccs;
        logic [XLEN-1:0]  handler;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic             arb_take;
    exc_cause_e       arb_cause;
    logic [VEC_W-1:0] arb_vec;
    logic [XLEN-1:0]  arb_ret;
    logic [XLEN-1:0]  slot_addr;
    logic [XLEN-1:0]  pushed_ccs;
    logic             idle;

    exc_cause_arb #(
        .XLEN    (XLEN),
        .VEC_W   (VEC_W),
        .IRQ_MIN (IRQ_MIN),
        .BRK_STEP(BRK_STEP)
    ) u_arb (
        .brk_req(brk_req_i),
        .brk_vec(brk_vec_i),
        .mmu_req(mmu_req_i),
        .mmu_vec(mmu_vec_i),
        .mmu_pc (mmu_pc_i),
        .irq_req(irq_req_i),
        .irq_vec(irq_vec_i),
        .irq_en (ccs_i[IE_BIT]),
        .cur_pc (cur_pc_i),
        .take   (arb_take),
        .cause  (arb_cause),
        .vec    (arb_vec),
        .ret_pc (arb_ret)
    );

    exc_vec_addr #(
        .XLEN (XLEN),
        .VEC_W(VEC_W)
    ) u_addr (
        .base(ebp_i),
        .vec (arb_vec),
        .addr(slot_addr)
    );

    exc_ccs_push #(
        .XLEN  (XLEN),
        .KEEP_W(KEEP_W),
        .PUSH_W(PUSH_W)
    ) u_push (
        .ccs_in (seq_q.ccs),
        .ccs_out(pushed_ccs)
    );

    assign idle = (seq_q.st == ST_IDLE);

    // next-state computation
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (arb_take) begin
                    seq_d.st    = ST_FETCH;
                    seq_d.cause = arb_cause;
                    seq_d.vec   = arb_vec;
                    seq_d.addr  = slot_addr;
                    seq_d.erp   = arb_ret;
                    seq_d.ccs   = ccs_i;
                end
            end
            ST_FETCH: begin
                if (rd_valid_i) begin
                    seq_d.handler = rd_data_i;
                    seq_d.st      = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                seq_d.st = ST_IDLE;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign accept_o  = idle && arb_take;
    assign busy_o    = !idle;
    assign rd_req_o  = (seq_q.st == ST_FETCH);
    assign rd_addr_o = seq_q.addr;
    assign commit_o  = (seq_q.st == ST_COMMIT);
    assign cause_o   = seq_q.cause;
    assign vec_o     = seq_q.vec;
    assign new_pc_o  = seq_q.handler;
    assign new_erp_o = seq_q.erp;
    assign new_ccs_o = pushed_ccs;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int XLEN    = 32,
    parameter int VEC_W   = 8,
    parameter int IRQ_MIN = 'h30,
    parameter int PUSH_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              accept_o,
    input logic              busy_o,
    input logic              rd_req_o,
    input logic [XLEN-1:0]   rd_addr_o,
    input logic              rd_valid_i,
    input logic [XLEN-1:0]   rd_data_i,
    input logic              commit_o,
    input logic [1:0]        cause_o,
    input logic [VEC_W-1:0]  vec_o,
    input logic [XLEN-1:0]   new_pc_o,
    input logic [PUSH_W-1:0] ccs_low,
    input logic              brk_req_i,
    input logic              mmu_req_i,
    input logic [VEC_W-1:0]  irq_vec_i,
    input logic              irq_en
);

    localparam logic [VEC_W-1:0] IrqFloor = VEC_W'(IRQ_MIN);

    // R1: request and address hold while the read is outstanding
    p_read_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o));

    // R1: returned word becomes the new program counter one cycle later
    p_read_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_valid_i |=> commit_o && (new_pc_o == $past(rd_data_i)));

    // R5: an interrupt-only acceptance needs a vector in the interrupt range
    p_irq_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o && !brk_req_i && !mmu_req_i |-> irq_vec_i >= IrqFloor);

    // R5: committed interrupts carry an in-range vector
    p_irq_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o && (cause_o == 2'd3) |-> vec_o >= IrqFloor);

    // R6: an interrupt-only acceptance needs the enable flag
    p_irq_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o && !brk_req_i && !mmu_req_i |-> irq_en);

    // R7: pushed status has its low field cleared
    p_ccs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ccs_low == '0);

    // R9: acceptance only while idle, busy follows
    p_accept_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> !busy_o);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> busy_o && rd_req_o);

    // R9: commit is a single-cycle pulse inside the busy window, then idle
    p_commit_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> busy_o);

    p_commit_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o && !busy_o);

endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .XLEN   (XLEN),
    .VEC_W  (VEC_W),
    .IRQ_MIN(IRQ_MIN),
    .PUSH_W (PUSH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_o  (accept_o),
    .busy_o    (busy_o),
    .rd_req_o  (rd_req_o),
    .rd_addr_o (rd_addr_o),
    .rd_valid_i(rd_valid_i),
    .rd_data_i (rd_data_i),
    .commit_o  (commit_o),
    .cause_o   (cause_o),
    .vec_o     (vec_o),
    .new_pc_o  (new_pc_o),
    .ccs_low   (new_ccs_o[PUSH_W-1:0]),
    .brk_req_i (brk_req_i),
    .mmu_req_i (mmu_req_i),
    .irq_vec_i (irq_vec_i),
    .irq_en    (ccs_i[IE_BIT])
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] erp;
        logic [31:0] ccs;
        logic [7:0]  vec;
        logic [1:0]  cause;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0, ccs = '0, ebp = '0, mmu_pc = '0;
    logic        brk_req = 1'b0, mmu_req = 1'b0, irq_req = 1'b0;
    logic [7:0]  brk_vec = '0, mmu_vec = '0, irq_vec = '0;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic        accept_o, busy_o, rd_req_o, commit_o;
    logic [31:0] rd_addr_o, new_pc_o, new_erp_o, new_ccs_o;
    logic [1:0]  cause_o;
    logic [7:0]  vec_o;

    int   checks = 0;
    int   errors = 0;
    int   lat = 0;
    int   n_commit = 0;
    int   n_expect = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_pc_i  (cur_pc),
        .ccs_i     (ccs),
        .ebp_i     (ebp),
        .brk_req_i (brk_req),
        .brk_vec_i (brk_vec),
        .mmu_req_i (mmu_req),
        .mmu_vec_i (mmu_vec),
        .mmu_pc_i  (mmu_pc),
        .irq_req_i (irq_req),
        .irq_vec_i (irq_vec),
        .accept_o  (accept_o),
        .busy_o    (busy_o),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_valid_i(rd_valid),
        .rd_data_i (rd_data),
        .commit_o  (commit_o),
        .cause_o   (cause_o),
        .vec_o     (vec_o),
        .new_pc_o  (new_pc_o),
        .new_erp_o (new_erp_o),
        .new_ccs_o (new_ccs_o)
    );

    function automatic logic [31:0] table_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] push_ccs(input logic [31:0] c);
        return (c & 32'hC000_0000) | ((c << 12) >> 2);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // vector table model with programmable latency
    initial begin : responder
        int waited;
        waited = 0;
        forever begin
            @(negedge clk);
            if (rd_req_o) begin
                if (waited >= lat) begin
                    rd_valid = 1'b1;
                    rd_data  = table_word(rd_addr_o);
                end else begin
                    rd_valid = 1'b0;
                    waited++;
                end
            end else begin
                rd_valid = 1'b0;
                waited   = 0;
            end
        end
    end

    // monitor: compare each commit against the scoreboard
    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk);
            if (rst_n && commit_o) begin
                n_commit++;
                if (q.size() == 0) begin
                    chk(0, "R9", "unexpected commit", {30'b0, cause_o}, 32'h0);
                end else begin
                    e = q.pop_front();
                    chk(new_pc_o == e.pc, "R1", "handler pc", new_pc_o, e.pc);
                    chk(new_erp_o == e.erp, "R2/R3/R4", "return addr", new_erp_o, e.erp);
                    chk(new_ccs_o == e.ccs, "R7", "pushed status", new_ccs_o, e.ccs);
                    chk(vec_o == e.vec, "R2/R3/R4", "vector", {24'b0, vec_o}, {24'b0, e.vec});
                    chk(cause_o == e.cause, "R8", "cause", {30'b0, cause_o}, {30'b0, e.cause});
                    chk(busy_o == 1'b1, "R9", "busy at commit", {31'b0, busy_o}, 32'h1);
                end
            end
        end
    end

    // Present one request cycle; expected result follows the requirement rules.
    task automatic present(input logic b, input logic [7:0] bv,
                           input logic m, input logic [7:0] mv, input logic [31:0] mpc,
                           input logic i, input logic [7:0] iv,
                           input logic [31:0] pc, input logic [31:0] c,
                           input logic [31:0] base, input int lat_v, input string tag);
        exp_t e;
        bit   tk;
        logic [31:0] a;
        @(negedge clk);
        lat = lat_v;
        brk_req = b; brk_vec = bv; mmu_req = m; mmu_vec = mv; mmu_pc = mpc;
        irq_req = i; irq_vec = iv; cur_pc = pc; ccs = c; ebp = base;
        tk = 1'b1;
        if (m) begin
            e.cause = 2'd2; e.vec = mv; e.erp = mpc;
        end else if (b) begin
            e.cause = 2'd1; e.vec = bv; e.erp = pc + 32'd2;
        end else if (i && iv >= 8'h30 && c[8]) begin
            e.cause = 2'd3; e.vec = iv; e.erp = pc;
        end else begin
            tk = 1'b0;
            e.cause = 2'd0; e.vec = '0; e.erp = '0;
        end
        a     = base + {22'b0, e.vec, 2'b00};
        e.pc  = table_word(a);
        e.ccs = push_ccs(c);
        #1;
        chk(accept_o == tk, tag, "accept", {31'b0, accept_o}, {31'b0, tk});
        if (tk) begin
            q.push_back(e);
            n_expect++;
        end
        @(negedge clk);
        if (tk) begin
            chk(busy_o && rd_req_o, "R9", "busy+req after accept", {30'b0, busy_o, rd_req_o}, 32'h3);
            chk(rd_addr_o == a, "R1", "table address", rd_addr_o, a);
        end else begin
            chk(!busy_o, tag, "stays idle", {31'b0, busy_o}, 32'h0);
        end
        brk_req = 1'b0; mmu_req = 1'b0; irq_req = 1'b0;
        while (busy_o) @(negedge clk);
        chk(q.size() == 0, tag, "scoreboard drained", q.size(), 32'h0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        exp_t e;
        repeat (3) @(negedge clk);
        chk(!busy_o && !rd_req_o && !commit_o, "R9", "reset state",
            {29'b0, busy_o, rd_req_o, commit_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: software break
        present(1, 8'h05, 0, 8'h00, 32'h0, 0, 8'h00, 32'h0000_1000, 32'h1234_5678, 32'h4000_0000, 0, "R2");
        // R2: return address wraps past the top
        present(1, 8'h7F, 0, 8'h00, 32'h0, 0, 8'h00, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0000_0100, 1, "R2");
        // R3: MMU fault
        present(0, 8'h00, 1, 8'h0E, 32'h2222_0010, 0, 8'h00, 32'h3333_0000, 32'h0000_0100, 32'h8000_0000, 2, "R3");
        // R4: interrupt, smallest vector in range
        present(0, 8'h00, 0, 8'h00, 32'h0, 1, 8'h30, 32'h0000_2000, 32'hC000_0100, 32'h4000_0000, 1, "R4");
        // R4/R1/R7: largest vector, base wraps, status all ones
        present(0, 8'h00, 0, 8'h00, 32'h0, 1, 8'hFF, 32'h0000_2004, 32'hFFFF_FFFF, 32'hFFFF_FF00, 3, "R4");
        // R5: vector just below the interrupt range
        present(0, 8'h00, 0, 8'h00, 32'h0, 1, 8'h2F, 32'h0000_2008, 32'h0000_0100, 32'h4000_0000, 0, "R5");
        // R8: all three at once -> MMU fault
        present(1, 8'h06, 1, 8'h0B, 32'h5555_0000, 1, 8'h40, 32'h0000_3000, 32'h0000_0100, 32'h4000_0000, 0, "R8");
        // R8: break beats interrupt
        present(1, 8'h06, 0, 8'h00, 32'h0, 1, 8'h40, 32'h0000_3010, 32'h0000_0100, 32'h4000_0000, 2, "R8");

        // R6: request held with interrupts disabled, then enabled
        @(negedge clk);
        lat = 1;
        irq_req = 1'b1; irq_vec = 8'h44; cur_pc = 32'h0000_4000;
        ccs = 32'h4000_0000; ebp = 32'h1000_0000;
        for (int k = 0; k < 4; k++) begin
            #1;
            chk(!accept_o && !busy_o, "R6", "masked interrupt not taken",
                {30'b0, accept_o, busy_o}, 32'h0);
            @(negedge clk);
        end
        ccs = 32'h4000_0100;
        e.cause = 2'd3; e.vec = 8'h44; e.erp = 32'h0000_4000;
        e.pc = table_word(32'h1000_0000 + 32'h110); e.ccs = push_ccs(32'h4000_0100);
        #1;
        chk(accept_o == 1'b1, "R6", "taken once enabled", {31'b0, accept_o}, 32'h1);
        q.push_back(e); n_expect++;
        @(negedge clk);
        irq_req = 1'b0;
        while (busy_o) @(negedge clk);

        // R9: causes raised while busy are ignored
        @(negedge clk);
        lat = 3;
        brk_req = 1'b1; brk_vec = 8'h09; cur_pc = 32'h0000_5000;
        ccs = 32'h0000_0000; ebp = 32'h2000_0000;
        e.cause = 2'd1; e.vec = 8'h09; e.erp = 32'h0000_5002;
        e.pc = table_word(32'h2000_0024); e.ccs = 32'h0;
        #1;
        chk(accept_o == 1'b1, "R9", "break accepted", {31'b0, accept_o}, 32'h1);
        q.push_back(e); n_expect++;
        @(negedge clk);
        brk_req = 1'b0; mmu_req = 1'b1; mmu_vec = 8'h0C; mmu_pc = 32'h7777_0000;
        #1;
        chk(!accept_o, "R9", "no accept while busy", {31'b0, accept_o}, 32'h0);
        @(negedge clk);
        #1;
        chk(!accept_o, "R9", "no accept while busy", {31'b0, accept_o}, 32'h0);
        mmu_req = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(n_commit == n_expect, "R9", "commit count", n_commit, n_expect);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule